// File: doc/BRIEF.md
# Segment Access Protection Checker

This block sits between an address-generation stage and the memory pipeline. It judges one memory access per cycle against a segment descriptor that has already been fetched and cached elsewhere. A request brings a byte offset into the segment, an access length, an access kind (read, write or instruction fetch) and the privilege level of the running code. The cached descriptor brings the segment base, the last valid byte offset (the limit), a present bit, a code/data bit, a single permission bit and a two-bit descriptor privilege level.

All checks are made in the same cycle: presence, bounds, type legality and the data privilege rule. The verdict is registered. One cycle after a valid request, the block raises either a grant strobe or a fault strobe. A fault carries a two-bit cause. The 32-bit linear address (base plus offset) is registered with the verdict, so that a granted access can go straight on to the next stage.

Privilege levels run from 0, the most trusted, to 3, the least trusted. The bounds check uses the offset of the last byte of the access, so an access that starts inside the segment but ends outside it is refused.

Top module: `seg_access_checker`

## Requirements
- R1: One cycle after a valid request, `lin_addr` holds `desc_base + req_offset` modulo 2^32.
- R2: Let last = `req_offset + req_len_m1`, computed without truncation. If last is greater than `desc_limit`, the access faults with cause 2'b01. This includes a sum that wraps past 2^32 and an access that starts inside the limit and ends outside it.
- R3: A write (`req_kind` 2'b01) to a code segment (`desc_code`=1) faults with cause 2'b10.
- R4: An execute (`req_kind` 2'b10) from a data segment (`desc_code`=0) faults with cause 2'b10.
- R5: The following also fault with cause 2'b10: a read (`req_kind` 2'b00) of a code segment whose `desc_rw` is 0, a write to a data segment whose `desc_rw` is 0, and the reserved kind 2'b11 on any segment.
- R6: A data-segment access with `req_cpl` numerically greater than `desc_dpl` faults with cause 2'b11. Code-segment accesses are not privilege checked.
- R7: A descriptor with `desc_present`=0 faults with cause 2'b00, whatever the other inputs are.
- R8: When several checks fail, the cause reported is taken by this priority: not present, then limit, then type, then privilege.
- R9: One cycle after each valid request, exactly one of `acc_grant` and `acc_fault` is high, each for a single cycle. Neither is high after a cycle with no request. `fault_cause` reads 2'b00 whenever `acc_fault` is low.
- R10: While reset is held, and after it, `acc_grant`, `acc_fault`, `fault_cause` and `lin_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_offset | input | 32 | Byte offset into the segment |
| req_kind | input | 2 | 00 read, 01 write, 10 execute, 11 reserved |
| req_len_m1 | input | 2 | Access length in bytes minus one |
| req_cpl | input | 2 | Current privilege level |
| desc_base | input | 32 | Segment base address |
| desc_limit | input | 32 | Highest valid byte offset |
| desc_present | input | 1 | Descriptor present |
| desc_code | input | 1 | 1 code segment, 0 data segment |
| desc_rw | input | 1 | Code: readable; data: writable |
| desc_dpl | input | 2 | Descriptor privilege level |
| acc_grant | output | 1 | Access granted (one-cycle strobe) |
| acc_fault | output | 1 | Access refused (one-cycle strobe) |
| fault_cause | output | 2 | 00 absent, 01 limit, 10 type, 11 privilege |
| lin_addr | output | 32 | Registered linear address |

## Verification
Directed requests fix the edges of the bounds check. They place the last byte exactly on the limit and one byte past it, use a multi-byte access that straddles the limit, and use an offset near 2^32 that wraps. These cases separate a check on the last byte from a check on the first byte, and a wide compare from a truncated one. A second group sets up several faults at once: absent plus out of bounds, out of bounds plus wrong type, and wrong type plus too little privilege. This group exposes any error in the priority order. Each kind is then tried against each segment class, with the permission bit both set and clear, and a CPL/DPL sweep runs over code and data segments. Together these show that the privilege rule applies to data only and that each type rule is tied to its own kind. A long run of mixed random requests and idle cycles is compared cycle by cycle with a behavioural model, which also checks that the strobes stay single-cycle and appear only after requests.

// File: rtl/segchk_pkg.sv
package segchk_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    CAUSE_ABSENT = 2'b00,
    CAUSE_LIMIT  = 2'b01,
    CAUSE_TYPE   = 2'b10,
    CAUSE_PRIV   = 2'b11
  } fault_cause_e;

  localparam int PL_W = 2;

endpackage

// File: rtl/segchk_addr.sv
module segchk_addr #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] offset,
  output logic [AW-1:0] lin
);

  function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] a,
                                             input logic [AW-1:0] b);
    logic [AW:0] full;
    full = {1'b0, a} + {1'b0, b};
    return full[AW-1:0];
  endfunction

  assign lin = wrap_add(base, offset);

endmodule

// File: rtl/segchk_limit.sv
module segchk_limit #(
  parameter int AW = 32,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] offset,
  input  logic [LW-1:0] len_m1,
  input  logic [AW-1:0] limit,
  output logic          over
);

  localparam int SW = AW + 1;

  function automatic logic [SW-1:0] last_byte(input logic [AW-1:0] off,
                                              input logic [LW-1:0] lm1);
    return {1'b0, off} + SW'(lm1);
  endfunction

  logic [SW-1:0] last_w;

  assign last_w = last_byte(offset, len_m1);
  assign over   = (last_w > {1'b0, limit});

  // R2: a wrapping access can never be inside the segment
  p_wrap_faults_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((offset + AW'(len_m1)) < offset) |-> over);

  // R2: a single byte at or below the limit is in bounds
  p_byte_inside_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (len_m1 == '0 && offset <= limit) |-> !over);

endmodule

// File: rtl/segchk_rules.sv
module segchk_rules
  import segchk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            is_code,
  input  logic            rw_ok,
  input  logic [PL_W-1:0] dpl,
  input  logic [PL_W-1:0] cpl,
  input  logic [1:0]      kind,
  output logic            type_bad,
  output logic            priv_bad
);

  function automatic logic kind_illegal(input logic code, input logic rw,
                                        input logic [1:0] k);
    logic bad;
    case (acc_kind_e'(k))
      ACC_READ:  bad = code && !rw;
      ACC_WRITE: bad = code || !rw;
      ACC_EXEC:  bad = !code;
      default:   bad = 1'b1;
    endcase
    return bad;
  endfunction

  function automatic logic lacks_priv(input logic code,
                                      input logic [PL_W-1:0] c,
                                      input logic [PL_W-1:0] d);
    return !code && (c > d);
  endfunction

  assign type_bad = kind_illegal(is_code, rw_ok, kind);
  assign priv_bad = lacks_priv(is_code, cpl, dpl);

  // R3: writing a code segment is never legal
  p_code_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_code && kind == ACC_WRITE) |-> type_bad);

  // R4: fetching from a data segment is never legal
  p_data_exec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_code && kind == ACC_EXEC) |-> type_bad);

  // R6: code segments carry no privilege verdict
  p_code_no_priv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_code |-> !priv_bad);

endmodule

// File: rtl/seg_access_checker.sv
module seg_access_checker
  import segchk_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_offset,
  input  logic [1:0]      req_kind,
  input  logic [LW-1:0]   req_len_m1,
  input  logic [PL_W-1:0] req_cpl,
  input  logic [AW-1:0]   desc_base,
  input  logic [AW-1:0]   desc_limit,
  input  logic            desc_present,
  input  logic            desc_code,
  input  logic            desc_rw,
  input  logic [PL_W-1:0] desc_dpl,
  output logic            acc_grant,
  output logic            acc_fault,
  output logic [1:0]      fault_cause,
  output logic [AW-1:0]   lin_addr
);

  // named internal events, visible to assertions
  logic          absent_w;
  logic          over_w;
  logic          type_bad_w;
  logic          priv_bad_w;
  logic          any_bad_w;
  logic [AW-1:0] lin_w;
  fault_cause_e  cause_w;
  logic          req_q;

  segchk_addr #(.AW(AW)) u_addr (
    .base   (desc_base),
    .offset (req_offset),
    .lin    (lin_w)
  );

  segchk_limit #(.AW(AW), .LW(LW)) u_limit (
    .clk    (clk),
    .rst_n  (rst_n),
    .offset (req_offset),
    .len_m1 (req_len_m1),
    .limit  (desc_limit),
    .over   (over_w)
  );

  segchk_rules u_rules (
    .clk      (clk),
    .rst_n    (rst_n),
    .is_code  (desc_code),
    .rw_ok    (desc_rw),
    .dpl      (desc_dpl),
    .cpl      (req_cpl),
    .kind     (req_kind),
    .type_bad (type_bad_w),
    .priv_bad (priv_bad_w)
  );

  assign absent_w  = !desc_present;
  assign any_bad_w = absent_w | over_w | type_bad_w | priv_bad_w;

  // priority: absent, limit, type, privilege
  always_comb begin
    if (absent_w)        cause_w = CAUSE_ABSENT;
    else if (over_w)     cause_w = CAUSE_LIMIT;
    else if (type_bad_w) cause_w = CAUSE_TYPE;
    else                 cause_w = CAUSE_PRIV;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_grant   <= 1'b0;
      acc_fault   <= 1'b0;
      fault_cause <= CAUSE_ABSENT;
      lin_addr    <= '0;
      req_q       <= 1'b0;
    end else begin
      req_q     <= req_valid;
      acc_grant <= req_valid && !any_bad_w;
      acc_fault <= req_valid && any_bad_w;
      if (req_valid) begin
        lin_addr    <= lin_w;
        fault_cause <= any_bad_w ? cause_w : CAUSE_ABSENT;
      end else begin
        fault_cause <= CAUSE_ABSENT;
      end
    end
  end

  // R1: registered linear address follows the request by one cycle
  p_lin_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> lin_addr == $past(desc_base + req_offset));

  // R7: an absent descriptor overrides every other check
  p_absent_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && absent_w) |=> acc_fault && fault_cause == CAUSE_ABSENT);

  // R8: bounds violation outranks type and privilege
  p_limit_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !absent_w && over_w) |=> acc_fault && fault_cause == CAUSE_LIMIT);

  // R8: type violation outranks privilege
  p_type_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && desc_present && !over_w && type_bad_w)
      |=> acc_fault && fault_cause == CAUSE_TYPE);

  // R9: never both strobes
  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_grant && acc_fault));

  // R9: a verdict appears only after a request
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_q |-> !acc_grant && !acc_fault);

  // R9: a request always yields a verdict
  p_req_answered_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (acc_grant || acc_fault));

  // R9: cause is clear when there is no fault
  p_cause_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_fault |-> fault_cause == CAUSE_ABSENT);

endmodule

// File: tb/seg_access_checker_bench.sv
module seg_access_checker_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_offset = '0;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_len_m1 = '0;
  logic [1:0]  req_cpl = '0;
  logic [31:0] desc_base = '0;
  logic [31:0] desc_limit = '0;
  logic        desc_present = 1'b0;
  logic        desc_code = 1'b0;
  logic        desc_rw = 1'b0;
  logic [1:0]  desc_dpl = '0;
  logic        acc_grant;
  logic        acc_fault;
  logic [1:0]  fault_cause;
  logic [31:0] lin_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  seg_access_checker u_seg_access_checker (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid),
    .req_offset (req_offset), .req_kind (req_kind), .req_len_m1 (req_len_m1),
    .req_cpl (req_cpl), .desc_base (desc_base), .desc_limit (desc_limit),
    .desc_present (desc_present), .desc_code (desc_code), .desc_rw (desc_rw),
    .desc_dpl (desc_dpl), .acc_grant (acc_grant), .acc_fault (acc_fault),
    .fault_cause (fault_cause), .lin_addr (lin_addr)
  );

  task automatic chk(input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: 0 grant, 1 absent, 2 limit, 3 type, 4 privilege
  function automatic int verdict(input longint off, input int lm1, input longint lim,
                                 input int kind, input int cpl, input int dpl,
                                 input bit pres, input bit code, input bit rw);
    bit illegal;
    if (!pres) return 1;
    if (off + lm1 > lim) return 2;
    illegal = (kind == 3) || (code && kind == 1) || (!code && kind == 2) ||
              (code && kind == 0 && !rw) || (!code && kind == 1 && !rw);
    if (illegal) return 3;
    if (!code && cpl > dpl) return 4;
    return 0;
  endfunction

  // called at a falling edge; compares after the next rising edge
  task automatic step(input bit v, input logic [31:0] off, input int kind,
                      input int lm1, input int cpl, input logic [31:0] base,
                      input logic [31:0] lim, input bit pres, input bit code,
                      input bit rw, input int dpl, input string tag);
    int vd;
    longint exp_addr;
    req_valid = v; req_offset = off; req_kind = 2'(kind); req_len_m1 = 2'(lm1);
    req_cpl = 2'(cpl); desc_base = base; desc_limit = lim; desc_present = pres;
    desc_code = code; desc_rw = rw; desc_dpl = 2'(dpl);
    vd = verdict(longint'(off), lm1, longint'(lim), kind, cpl, dpl, pres, code, rw);
    exp_addr = (longint'(base) + longint'(off)) % 64'h1_0000_0000;
    @(posedge clk);
    @(negedge clk);
    if (!v) begin
      chk(tag, "grant idle", acc_grant, 0);
      chk(tag, "fault idle", acc_fault, 0);
      chk(tag, "cause idle", fault_cause, 0);
    end else begin
      chk(tag, "grant", acc_grant, vd == 0);
      chk(tag, "fault", acc_fault, vd != 0);
      chk(tag, "cause", fault_cause, (vd == 0) ? 0 : vd - 1);
      chk(tag, "lin_addr", lin_addr, exp_addr);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "grant", acc_grant, 0);
    chk("R10", "fault", acc_fault, 0);
    chk("R10", "cause", fault_cause, 0);
    chk("R10", "lin_addr", lin_addr, 0);
    rst_n = 1'b1;

    // R1: address formation, plus wrap of the addition
    step(1, 32'h10, 0, 0, 0, 32'h1000, 32'hFF, 1, 0, 1, 0, "R1");
    step(1, 32'h20, 0, 0, 0, 32'hFFFF_FFF0, 32'hFF, 1, 0, 1, 0, "R1");
    // R2: last byte on the limit, one past, straddle, wrap
    step(1, 32'hFC, 0, 3, 0, 32'h0, 32'hFF, 1, 0, 1, 0, "R2");
    step(1, 32'hFD, 0, 3, 0, 32'h0, 32'hFF, 1, 0, 1, 0, "R2");
    step(1, 32'h100, 0, 0, 0, 32'h0, 32'hFF, 1, 0, 1, 0, "R2");
    step(1, 32'hFFFF_FFFE, 0, 3, 0, 32'h0, 32'hFFFF_FFFF, 1, 0, 1, 0, "R2");
    step(1, 32'hFFFF_FFFF, 0, 0, 0, 32'h0, 32'hFFFF_FFFF, 1, 0, 1, 0, "R2");
    // R3 / R4 / R5: type legality
    step(1, 32'h4, 1, 0, 0, 32'h0, 32'hFF, 1, 1, 1, 0, "R3");
    step(1, 32'h4, 2, 0, 0, 32'h0, 32'hFF, 1, 0, 1, 0, "R4");
    step(1, 32'h4, 2, 0, 3, 32'h0, 32'hFF, 1, 1, 0, 0, "R4");
    step(1, 32'h4, 0, 0, 0, 32'h0, 32'hFF, 1, 1, 0, 0, "R5");
    step(1, 32'h4, 0, 0, 0, 32'h0, 32'hFF, 1, 1, 1, 0, "R5");
    step(1, 32'h4, 1, 0, 0, 32'h0, 32'hFF, 1, 0, 0, 0, "R5");
    step(1, 32'h4, 1, 0, 0, 32'h0, 32'hFF, 1, 0, 1, 0, "R5");
    step(1, 32'h4, 3, 0, 0, 32'h0, 32'hFF, 1, 1, 1, 0, "R5");
    step(1, 32'h4, 3, 0, 0, 32'h0, 32'hFF, 1, 0, 1, 3, "R5");
    // R6: privilege sweep on data and code
    for (int c = 0; c < 4; c++)
      for (int d = 0; d < 4; d++) begin
        step(1, 32'h8, 0, 1, c, 32'h40, 32'hFF, 1, 0, 1, d, "R6");
        step(1, 32'h8, 2, 1, c, 32'h40, 32'hFF, 1, 1, 0, d, "R6");
      end
    // R7: absent descriptor beats everything
    step(1, 32'h4, 0, 0, 0, 32'h0, 32'hFF, 0, 0, 1, 0, "R7");
    step(1, 32'h400, 2, 3, 3, 32'h0, 32'hFF, 0, 0, 0, 0, "R7");
    // R8: combined faults
    step(1, 32'h400, 1, 0, 3, 32'h0, 32'hFF, 1, 1, 0, 0, "R8");
    step(1, 32'h4, 1, 0, 3, 32'h0, 32'hFF, 1, 0, 0, 0, "R8");
    step(1, 32'h400, 0, 0, 3, 32'h0, 32'hFF, 1, 0, 1, 0, "R8");
    // R9: idle cycles between and after requests
    step(0, 32'h4, 1, 0, 3, 32'h0, 32'hFF, 1, 1, 0, 0, "R9");
    step(1, 32'h4, 0, 0, 0, 32'h0, 32'hFF, 1, 0, 1, 0, "R9");
    step(0, 32'h4, 0, 0, 0, 32'h0, 32'hFF, 1, 0, 1, 0, "R9");
    step(0, 32'h4, 0, 0, 0, 32'h0, 32'hFF, 0, 0, 1, 0, "R9");

    // mixed random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] off, lim;
      lim = $urandom;
      case ($urandom_range(0, 3))
        0: off = lim - 32'($urandom_range(0, 4));
        1: off = lim + 32'($urandom_range(0, 4));
        2: off = 32'hFFFF_FFFF - 32'($urandom_range(0, 3));
        default: off = $urandom;
      endcase
      step($urandom_range(0, 4) != 0, off, $urandom_range(0, 3),
           $urandom_range(0, 3), $urandom_range(0, 3), $urandom, lim,
           $urandom_range(0, 7) != 0, 1'($urandom), 1'($urandom),
           $urandom_range(0, 3), "R9");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule